// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that sits behind a four-dword register window with per-byte write enables. Software programs a timeout in ticks and writes the reload location to restart the count. A halt bit stops the count. A free-running prescaler divides the core clock into ticks. With a one-second-class tick of about 0.6 s, a delay of S seconds is programmed as S*10/6 ticks.

When the count runs out, a sticky timeout flag is set and the counter refills from the timeout value. If a second run-out follows without a reload in between, a second-stage flag is set. In that case the block also raises a one-cycle system action request, unless the `no_reboot` input is high. A lock bit can be set once and stays set until reset. A control word, two message bytes and an interrupt-generation byte are held as plain storage.

Register layout (dword address, bit positions within the 32-bit word):
- Address 0: bits 15:0 read the live count, and a write to lanes 0 or 1 reloads the count. Bits 31:16 hold the timeout value.
- Address 1: status flags.
- Address 2: control.
- Address 3: storage bytes.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, address 0 reads 0x0004_0000 (count 0, timeout 4). Address 1 reads 0. Address 2 reads 0x0008_0000. Address 3 reads 0x0003_0000.
- R2: A write changes only the byte lanes whose `be` bit is set. All other bytes keep their value.
- R3: A write at address 0 with `be[0]` or `be[1]` set loads the count from the timeout value. When lanes 2 or 3 are written in the same access, the new value is used. The write also clears the prescaler and disarms the second stage.
- R4: While running, the count drops by one every PRESCALE cycles after a reload. From a load of N, it reads 1 after N-1 ticks, and the timeout flag is still clear at that point.
- R5: While the halt bit (address 2, bit 11) is 1, the count and the prescaler hold. Writing 0 resumes counting.
- R6: A tick that finds the count at 1 or 0 is an expiry. It sets the timeout flag (address 1, bit 3), refills the count from the timeout value, and arms the second stage.
- R7: Writing 1 to a status flag clears it. The flags are bit 3, bit 17 and bit 18 of address 1. When an expiry sets a flag in the same cycle as the clear, the set wins.
- R8: An expiry while armed (no reload since the previous expiry) sets the second-stage flag (address 1, bit 17).
- R9: On an armed expiry with `no_reboot` low, `act_req` is high for exactly one cycle and the action flag (address 1, bit 18) is set. With `no_reboot` high, neither happens.
- R10: Writing 1 to the lock bit (address 2, bit 12) sets it. Later writes of 0 leave it set, and only reset clears it.
- R11: The timeout field keeps only its low TMO_W bits. Writing 0xFFFF reads back 2^TMO_W-1, and a full-scale count runs to 1 before expiring.
- R12: Address 3 holds two message bytes (lanes 0 and 1) and the interrupt-generation byte (lane 2). Lane 3 reads 0. Address 2 bits 31:16 are a 16-bit storage word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_reboot | input | 1 | High blocks the system action request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Dword address within the window |
| be | input | 4 | Byte-lane write enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| act_req | output | 1 | One-cycle system action request |

## Verification
The embedded properties assume reset is asserted from time zero. They also assume every input changes away from the rising edge. The hold check assumes a write to the halt bit takes effect only after the edge that captures it. The stimulus meets these conditions by driving every input a short time after an edge and holding it through the next one. Random timeout writes are biased to small values so that both expiry stages occur often. The halt bit is set only rarely so the counter keeps running.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int PRESCALE = 600000,
  parameter int TMO_W    = 10
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        no_reboot,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        act_req
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [PRE_W-1:0] pre;
  logic [TMO_W-1:0] cnt, tmo, tmo_nx;
  logic [15:0] tmo_ext, tmo_wr, ctrl2;
  logic [7:0]  msg_lo, msg_hi, swi;
  logic halt, lock, armed, st_to, st_2nd, st_act;
  logic wr0, wr1, wr2, wr3, reload, tick, expire;

  assign wr0 = wr_en && addr == 2'd0;
  assign wr1 = wr_en && addr == 2'd1;
  assign wr2 = wr_en && addr == 2'd2;
  assign wr3 = wr_en && addr == 2'd3;

  assign tmo_ext = 16'(tmo);
  assign tmo_wr  = {be[3] ? wdata[31:24] : tmo_ext[15:8],
                    be[2] ? wdata[23:16] : tmo_ext[7:0]};
  assign tmo_nx  = wr0 ? tmo_wr[TMO_W-1:0] : tmo;

  assign reload = wr0 && (be[0] || be[1]);
  assign tick   = !halt && pre == PRE_LAST;
  assign expire = tick && !reload && cnt <= ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      tmo     <= TMO_W'(4);
      halt    <= 1'b0;
      lock    <= 1'b0;
      armed   <= 1'b0;
      st_to   <= 1'b0;
      st_2nd  <= 1'b0;
      st_act  <= 1'b0;
      act_req <= 1'b0;
      ctrl2   <= 16'h0008;
      msg_lo  <= 8'h00;
      msg_hi  <= 8'h00;
      swi     <= 8'h03;
    end else begin
      tmo <= tmo_nx;

      if (reload)     pre <= '0;
      else if (!halt) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;

      if (reload)    cnt <= tmo_nx;
      else if (tick) cnt <= (cnt <= ONE) ? tmo : cnt - ONE;

      if (reload)      armed <= 1'b0;
      else if (expire) armed <= 1'b1;

      act_req <= expire && armed && !no_reboot;

      if (wr1 && be[0] && wdata[3])  st_to  <= 1'b0;
      if (wr1 && be[2] && wdata[17]) st_2nd <= 1'b0;
      if (wr1 && be[2] && wdata[18]) st_act <= 1'b0;
      if (expire) st_to <= 1'b1;
      if (expire && armed) st_2nd <= 1'b1;
      if (expire && armed && !no_reboot) st_act <= 1'b1;

      if (wr2 && be[1]) begin
        halt <= wdata[11];
        lock <= lock | wdata[12];
      end
      if (wr2 && be[2]) ctrl2[7:0]  <= wdata[23:16];
      if (wr2 && be[3]) ctrl2[15:8] <= wdata[31:24];

      if (wr3 && be[0]) msg_lo <= wdata[7:0];
      if (wr3 && be[1]) msg_hi <= wdata[15:8];
      if (wr3 && be[2]) swi    <= wdata[23:16];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {tmo_ext, 16'(cnt)};
      2'd1:    rdata = {13'b0, st_act, st_2nd, 1'b0, 12'b0, st_to, 3'b0};
      2'd2:    rdata = {ctrl2, 3'b0, lock, halt, 11'b0};
      default: rdata = {8'h00, swi, msg_hi, msg_lo};
    endcase
  end

  // R9
  act_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> $past(!no_reboot));

  // R9
  act_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> (st_act && st_2nd && st_to));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> lock);

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(wr_en && addr == 2'd0 && (be[0] || be[1]))) |-> $stable(cnt));

  // R8
  second_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_2nd) |-> st_to);
endmodule

// File: tb/wdog_twostage_test.sv
`timescale 1ns/100ps
module wdog_twostage_test;
  localparam int PS = 4;
  localparam int TW = 10;
  localparam logic [15:0] MASK = 16'((1 << TW) - 1);

  logic clk = 1'b0, rst_n = 1'b0, no_reboot = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [3:0] be = 4'd0;
  logic [31:0] wdata = 32'd0, rdata;
  logic act_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_twostage #(.PRESCALE(PS), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .no_reboot(no_reboot), .wr_en(wr_en),
    .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .act_req(act_req));

  logic [15:0] m_cnt = 16'd0, m_tmo = 16'd4, m_ctrl2 = 16'h0008;
  logic [7:0]  m_msg_lo = 8'h00, m_msg_hi = 8'h00, m_swi = 8'h03;
  int m_pre = 0;
  bit m_halt = 0, m_lock = 0, m_armed = 0, m_to = 0, m_2nd = 0, m_actf = 0, m_act = 0;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {m_tmo, m_cnt};
      2'd1:    return {13'b0, m_actf, m_2nd, 1'b0, 12'b0, m_to, 3'b0};
      2'd2:    return {m_ctrl2, 3'b0, m_lock, m_halt, 11'b0};
      default: return {8'h00, m_swi, m_msg_hi, m_msg_lo};
    endcase
  endfunction

  task automatic model_update(input logic w, input logic [1:0] a, input logic [3:0] b,
                              input logic [31:0] d, input logic nr);
    logic [15:0] tn;
    bit rl, tk, ex;
    tn = m_tmo;
    if (w && a == 2'd0) begin
      if (b[2]) tn[7:0]  = d[23:16];
      if (b[3]) tn[15:8] = d[31:24];
      tn = tn & MASK;
    end
    rl = w && a == 2'd0 && (b[0] || b[1]);
    tk = !m_halt && m_pre == PS - 1;
    ex = tk && !rl && m_cnt <= 16'd1;
    m_act = ex && m_armed && !nr;
    if (w && a == 2'd1) begin
      if (b[0] && d[3])  m_to   = 0;
      if (b[2] && d[17]) m_2nd  = 0;
      if (b[2] && d[18]) m_actf = 0;
    end
    if (ex) begin
      m_to = 1;
      if (m_armed) begin
        m_2nd = 1;
        if (!nr) m_actf = 1;
      end
    end
    if (rl) m_cnt = tn;
    else if (tk) m_cnt = (m_cnt <= 16'd1) ? m_tmo : m_cnt - 16'd1;
    if (rl) m_pre = 0;
    else if (!m_halt) m_pre = (m_pre == PS - 1) ? 0 : m_pre + 1;
    if (rl) m_armed = 0;
    else if (ex) m_armed = 1;
    m_tmo = tn;
    if (w && a == 2'd2) begin
      if (b[1]) begin m_halt = d[11]; m_lock = m_lock | d[12]; end
      if (b[2]) m_ctrl2[7:0]  = d[23:16];
      if (b[3]) m_ctrl2[15:8] = d[31:24];
    end
    if (w && a == 2'd3) begin
      if (b[0]) m_msg_lo = d[7:0];
      if (b[1]) m_msg_hi = d[15:8];
      if (b[2]) m_swi    = d[23:16];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [3:0] b,
                      input logic [31:0] d, input string tag);
    wr_en = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    model_update(w, a, b, d, no_reboot);
    #2;
    chk(tag, rdata, exp_rd(a));
    chk("R9 act_req", {31'b0, act_req}, {31'b0, m_act});
  endtask

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0:    return "R4 count";
      2'd1:    return "R6 status";
      2'd2:    return "R10 control";
      default: return "R12 storage";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset values
    step(0, 2'd0, 4'd0, 0, "R1"); chk("R1 addr0", rdata, 32'h0004_0000);
    step(0, 2'd1, 4'd0, 0, "R1"); chk("R1 addr1", rdata, 32'h0000_0000);
    step(0, 2'd2, 4'd0, 0, "R1"); chk("R1 addr2", rdata, 32'h0008_0000);
    step(0, 2'd3, 4'd0, 0, "R1"); chk("R1 addr3", rdata, 32'h0003_0000);

    step(1, 2'd2, 4'b0011, 32'h0000_0800, "R5");
    step(1, 2'd0, 4'b1100, 32'h0006_0000, "R3");
    step(1, 2'd0, 4'b0011, 32'h0, "R3"); chk("R3 reload", rdata, 32'h0006_0006);
    step(1, 2'd1, 4'b0001, 32'h8, "R7"); chk("R7 clear to", rdata, 32'h0);
    for (int i = 0; i < 10; i++) begin
      step(0, 2'd0, 4'd0, 0, "R5"); chk("R5 halted", rdata, 32'h0006_0006);
    end

    step(1, 2'd2, 4'b0011, 32'h0, "R5");
    for (int k = 1; k <= 49; k++) begin
      case (k)
        20: begin step(0, 2'd0, 0, 0, "R4"); chk("R4 count one", rdata, 32'h0006_0001); end
        21, 22, 23: begin step(0, 2'd1, 0, 0, "R4"); chk("R4 flag clear", rdata, 32'h0); end
        24: begin step(0, 2'd1, 0, 0, "R6"); chk("R6 first expiry", rdata, 32'h0000_0008); end
        25: begin step(0, 2'd0, 0, 0, "R6"); chk("R6 refill", rdata, 32'h0006_0006); end
        26: begin step(1, 2'd1, 4'b0001, 32'h8, "R7"); chk("R7 clear", rdata, 32'h0); end
        48: begin
          step(0, 2'd1, 0, 0, "R8"); chk("R8 second", rdata, 32'h0006_0008);
          chk("R9 pulse", {31'b0, act_req}, 32'd1);
        end
        49: begin step(0, 2'd0, 0, 0, "R9"); chk("R9 one cycle", {31'b0, act_req}, 32'd0); end
        default: step(0, 2'd0, 0, 0, "R4");
      endcase
    end

    no_reboot = 1'b1;
    step(1, 2'd1, 4'b0101, 32'h0006_0008, "R7"); chk("R7 clear all", rdata, 32'h0);
    step(1, 2'd0, 4'b0011, 32'h0, "R3");
    for (int k = 1; k <= 48; k++) step(0, 2'd1, 0, 0, "R9");
    chk("R9 gated", rdata, 32'h0002_0008);
    no_reboot = 1'b0;

    step(1, 2'd2, 4'b0011, 32'h0000_1800, "R10");
    step(1, 2'd2, 4'b0011, 32'h0000_0800, "R10"); chk("R10 lock stays", rdata, 32'h0008_1800);
    step(1, 2'd3, 4'b0101, 32'hA5B6_C7D8, "R12"); chk("R12 storage", rdata, 32'h00B6_00D8);
    step(1, 2'd2, 4'b1000, 32'h1200_0000, "R2"); chk("R2 lane3 only", rdata, 32'h1208_1800);

    step(1, 2'd0, 4'b1100, 32'hFFFF_0000, "R11"); chk("R11 mask", {16'h0, rdata[31:16]}, 32'h03FF);
    step(1, 2'd0, 4'b0011, 32'h0, "R11"); chk("R11 full load", {16'h0, rdata[15:0]}, 32'h03FF);
    step(1, 2'd1, 4'b0101, 32'h0006_0008, "R7");
    step(1, 2'd2, 4'b0011, 32'h0000_1000, "R5");
    for (int k = 1; k <= 4092; k++) begin
      if (k == 4088) begin
        step(0, 2'd0, 0, 0, "R11"); chk("R11 reads one", {16'h0, rdata[15:0]}, 32'd1);
      end else if (k == 4091) begin
        step(0, 2'd1, 0, 0, "R11"); chk("R11 not yet", {31'b0, rdata[3]}, 32'd0);
      end else if (k == 4092) begin
        step(0, 2'd1, 0, 0, "R11"); chk("R11 expiry", {31'b0, rdata[3]}, 32'd1);
      end else begin
        step(0, 2'd0, 0, 0, "R4");
      end
    end

    for (int n = 0; n < 20000; n++) begin
      logic [1:0] a;
      logic [3:0] b;
      logic [31:0] d;
      a = 2'($urandom % 4);
      if ($urandom % 64 == 0) no_reboot = ~no_reboot;
      if ($urandom % 8 == 0) begin
        b = 4'($urandom % 15 + 1);
        d = $urandom;
        if (a == 2'd2 && ($urandom % 8 != 0)) d[11] = 1'b0;
        if (a == 2'd0 && ($urandom % 16 != 0)) d[31:16] = 16'($urandom % 12);
        if (a == 2'd0 && ($urandom % 2 == 0)) b[1:0] = 2'b00;
        if (b == 4'd0) b = 4'b0100;
        step(1, a, b, d, "R2 write");
      end else begin
        step(0, a, 0, 0, tag_of(a));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule